// File: doc/BRIEF.md
# External Wait-Pin Monitor

This block decides, on every clock, whether the external device behind the chip-select currently being accessed is ready. Two wait inputs arrive from the board. Each chip-select names the pin that serves it, and each pin has its own polarity. When monitoring is enabled for the access direction in progress, the selected pin can hold off the access engine. This applies both during the initial access time and between beats of a burst.

Both pins first pass through a two-flop synchronizer. A chip-select configured for asynchronous accesses looks at the synchronized level on every clock. A chip-select configured for synchronous accesses looks only at a copy of that level, captured on the cycles where the access engine flags an external-clock edge. The read-type and write-type bits of the chip-select choose between these two schemes. Outside the monitor window given by the access engine, and whenever monitoring is off, the stall output stays low and only the engine's own access-time counters pace the access.

Top module: `wait_pin_monitor`

## Requirements
- R1: The pin-select field of chip-select c is `cs_pin_sel_i[c*SEL_W +: SEL_W]`. Value 0 routes `wait_pin_i[0]` and value 1 routes `wait_pin_i[1]`. A busy level on the pin that is not selected has no effect on `stall_o`.
- R2: Pin-select values 2 and 3 route `wait_pin_i[0]`.
- R3: Polarity is set per pin. `pin_active_low_i[p]` = 1 makes a low level on pin p mean "not ready", and 0 makes a high level mean "not ready". The opposite level means ready.
- R4: During a read (`acc_write_i` = 0), the pin is ignored when `cs_rd_mon_en_i[c]` is 0, and `stall_o` stays low.
- R5: During a write (`acc_write_i` = 1), the pin is ignored when `cs_wr_mon_en_i[c]` is 0, and `stall_o` stays low. The read enable plays no part in a write.
- R6: In asynchronous mode (the relevant bit of `cs_rd_sync_i` / `cs_wr_sync_i` is 0), a pin change shows on `stall_o` after exactly two rising clock edges, and not after one.
- R7: In synchronous mode (the bit is 1), the pin state is taken only at rising edges where `ext_clk_edge_i` is 1. It is held unchanged in between.
- R8: While `mon_window_i` is 0, `stall_o` is 0 whatever the pins and configuration.
- R9: `ready_o` is always the complement of `stall_o`.
- R10: After reset, the synchronous-mode captured state reads as ready. `stall_o` stays low in synchronous mode until the first capture strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wait_pin_i | input | NUM_PINS | Raw wait pins from the board |
| pin_active_low_i | input | NUM_PINS | Per-pin polarity, 1 = active low |
| cs_idx_i | input | CS_W | Index of the chip-select being accessed |
| cs_pin_sel_i | input | NUM_CS*SEL_W | Pin-select field per chip-select |
| cs_rd_mon_en_i | input | NUM_CS | Monitor pin during reads, per chip-select |
| cs_wr_mon_en_i | input | NUM_CS | Monitor pin during writes, per chip-select |
| cs_rd_sync_i | input | NUM_CS | Reads are synchronous, per chip-select |
| cs_wr_sync_i | input | NUM_CS | Writes are synchronous, per chip-select |
| acc_write_i | input | 1 | Current access direction, 1 = write |
| ext_clk_edge_i | input | 1 | Strobe marking an external-clock edge |
| mon_window_i | input | 1 | Engine is in a phase where the pin may stall it |
| stall_o | output | 1 | Device not ready, hold the access |
| ready_o | output | 1 | Device ready |

## Verification
The embedded properties check four things on every cycle. The synchronizer output equals the pin level two clocks earlier. The captured synchronous state changes only after a strobe. The stall stays low outside the window, and it stays low when the enable for the current direction is off. Pin routing, the treatment of select values 2 and 3, polarity per pin, and the isolation of one pin from the other cannot be seen by those properties. They are shown by the bench sweeping every combination of chip-select, select value, polarities, direction, enable, mode, window and pin levels. The exact one-edge versus two-edge latency and the reset-time ready state are shown by directed scenarios.

// File: rtl/wpm_pkg.sv
package wpm_pkg;
   typedef enum logic {
      DIR_READ  = 1'b0,
      DIR_WRITE = 1'b1
   } acc_dir_e;

   typedef enum logic {
      SAMPLE_LEVEL = 1'b0,
      SAMPLE_EDGE  = 1'b1
   } sample_mode_e;

   typedef struct packed {
      logic         mon_en;
      sample_mode_e mode;
   } mon_cfg_t;
endpackage

// File: rtl/wpm_sync.sv
module wpm_sync #(
   parameter int WIDTH = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   logic [WIDTH-1:0] meta_q;
   logic [WIDTH-1:0] stab_q;

   for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            meta_q[b] <= 1'b0;
            stab_q[b] <= 1'b0;
         end else begin
            meta_q[b] <= d_i[b];
            stab_q[b] <= meta_q[b];
         end
      end
   end

   assign q_o = stab_q;

   logic [1:0] age_q;
   always_ff @(posedge clk) begin
      if (!rst_n) age_q <= 2'd0;
      else if (age_q != 2'd2) age_q <= age_q + 2'd1;
   end

   // R6
   sync_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (age_q == 2'd2) |-> (q_o == $past(d_i, 2)));
endmodule

// File: rtl/wpm_pin_cond.sv
module wpm_pin_cond #(
   parameter int NUM_PINS = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] lvl_i,
   input  logic [NUM_PINS-1:0] active_low_i,
   input  logic                edge_i,
   output logic [NUM_PINS-1:0] busy_lvl_o,
   output logic [NUM_PINS-1:0] busy_cap_o
);
   logic [NUM_PINS-1:0] cap_q;

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      always_comb begin
         if (active_low_i[p]) busy_lvl_o[p] = ~lvl_i[p];
         else                 busy_lvl_o[p] =  lvl_i[p];
      end

      always_ff @(posedge clk) begin
         if (!rst_n)      cap_q[p] <= 1'b0;
         else if (edge_i) cap_q[p] <= busy_lvl_o[p];
      end
   end

   assign busy_cap_o = cap_q;

   // R7
   cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(edge_i) |-> $stable(busy_cap_o));
endmodule

// File: rtl/wpm_cfg_sel.sv
module wpm_cfg_sel
   import wpm_pkg::*;
#(
   parameter int NUM_CS   = 4,
   parameter int NUM_PINS = 2,
   parameter int SEL_W    = 2,
   localparam int CS_W    = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
   localparam int PIN_W   = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
   input  logic [CS_W-1:0]         cs_idx_i,
   input  logic [NUM_CS*SEL_W-1:0] pin_sel_i,
   input  logic [NUM_CS-1:0]       rd_en_i,
   input  logic [NUM_CS-1:0]       wr_en_i,
   input  logic [NUM_CS-1:0]       rd_sync_i,
   input  logic [NUM_CS-1:0]       wr_sync_i,
   input  acc_dir_e                dir_i,
   output logic [PIN_W-1:0]        pin_idx_o,
   output mon_cfg_t                cfg_o
);
   logic             cs_ok;
   logic [SEL_W-1:0] sel_field;

   if ((1 << CS_W) == NUM_CS) begin : g_cs_full
      assign cs_ok = 1'b1;
   end else begin : g_cs_partial
      assign cs_ok = (int'(cs_idx_i) < NUM_CS);
   end

   always_comb begin
      sel_field = '0;
      for (int c = 0; c < NUM_CS; c++) begin
         if (int'(cs_idx_i) == c) sel_field = pin_sel_i[c*SEL_W +: SEL_W];
      end
   end

   always_comb begin
      if (int'(sel_field) < NUM_PINS) pin_idx_o = sel_field[PIN_W-1:0];
      else                            pin_idx_o = '0;
   end

   always_comb begin
      cfg_o.mon_en = 1'b0;
      cfg_o.mode   = SAMPLE_LEVEL;
      if (cs_ok) begin
         if (dir_i == DIR_WRITE) begin
            cfg_o.mon_en = wr_en_i[cs_idx_i];
            cfg_o.mode   = sample_mode_e'(wr_sync_i[cs_idx_i]);
         end else begin
            cfg_o.mon_en = rd_en_i[cs_idx_i];
            cfg_o.mode   = sample_mode_e'(rd_sync_i[cs_idx_i]);
         end
      end
   end
endmodule

// File: rtl/wait_pin_monitor.sv
module wait_pin_monitor
   import wpm_pkg::*;
#(
   parameter int NUM_CS   = 4,
   parameter int NUM_PINS = 2,
   parameter int SEL_W    = 2,
   localparam int CS_W    = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
   localparam int PIN_W   = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [NUM_PINS-1:0]     wait_pin_i,
   input  logic [NUM_PINS-1:0]     pin_active_low_i,
   input  logic [CS_W-1:0]         cs_idx_i,
   input  logic [NUM_CS*SEL_W-1:0] cs_pin_sel_i,
   input  logic [NUM_CS-1:0]       cs_rd_mon_en_i,
   input  logic [NUM_CS-1:0]       cs_wr_mon_en_i,
   input  logic [NUM_CS-1:0]       cs_rd_sync_i,
   input  logic [NUM_CS-1:0]       cs_wr_sync_i,
   input  logic                    acc_write_i,
   input  logic                    ext_clk_edge_i,
   input  logic                    mon_window_i,
   output logic                    stall_o,
   output logic                    ready_o
);
   if (NUM_PINS < 1 || NUM_PINS > (1 << SEL_W)) begin : g_bad_pins
      $error("wait_pin_monitor: NUM_PINS must lie in 1 .. 2**SEL_W");
   end
   if (NUM_CS < 1) begin : g_bad_cs
      $error("wait_pin_monitor: NUM_CS must be at least 1");
   end
   if (SEL_W < 1) begin : g_bad_sel
      $error("wait_pin_monitor: SEL_W must be at least 1");
   end

   logic [NUM_PINS-1:0] pin_sync;
   logic [NUM_PINS-1:0] busy_lvl;
   logic [NUM_PINS-1:0] busy_cap;
   logic [PIN_W-1:0]    pin_idx;
   mon_cfg_t            cfg;
   logic                busy_sel;

   wpm_sync #(.WIDTH(NUM_PINS)) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (wait_pin_i),
      .q_o   (pin_sync)
   );

   wpm_pin_cond #(.NUM_PINS(NUM_PINS)) i_pin_cond (
      .clk          (clk),
      .rst_n        (rst_n),
      .lvl_i        (pin_sync),
      .active_low_i (pin_active_low_i),
      .edge_i       (ext_clk_edge_i),
      .busy_lvl_o   (busy_lvl),
      .busy_cap_o   (busy_cap)
   );

   wpm_cfg_sel #(
      .NUM_CS   (NUM_CS),
      .NUM_PINS (NUM_PINS),
      .SEL_W    (SEL_W)
   ) i_cfg_sel (
      .cs_idx_i  (cs_idx_i),
      .pin_sel_i (cs_pin_sel_i),
      .rd_en_i   (cs_rd_mon_en_i),
      .wr_en_i   (cs_wr_mon_en_i),
      .rd_sync_i (cs_rd_sync_i),
      .wr_sync_i (cs_wr_sync_i),
      .dir_i     (acc_dir_e'(acc_write_i)),
      .pin_idx_o (pin_idx),
      .cfg_o     (cfg)
   );

   always_comb begin
      if (cfg.mode == SAMPLE_EDGE) busy_sel = busy_cap[pin_idx];
      else                         busy_sel = busy_lvl[pin_idx];
   end

   assign stall_o = mon_window_i & cfg.mon_en & busy_sel;
   assign ready_o = ~stall_o;

   // R8
   window_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mon_window_i |-> !stall_o);

   // R4
   rd_mon_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!acc_write_i && (int'(cs_idx_i) < NUM_CS) && !cs_rd_mon_en_i[cs_idx_i]) |-> !stall_o);

   // R5
   wr_mon_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_write_i && (int'(cs_idx_i) < NUM_CS) && !cs_wr_mon_en_i[cs_idx_i]) |-> !stall_o);
endmodule

// File: tb/test_wait_pin_monitor.sv
module test_wait_pin_monitor;
   localparam int CLK_PERIOD = 10;
   localparam int NUM_CS     = 4;
   localparam int NUM_PINS   = 2;
   localparam int SEL_W      = 2;
   localparam int CS_W       = 2;

   logic                    clk = 1'b0;
   logic                    rst_n = 1'b0;
   logic [NUM_PINS-1:0]     wait_pin = '0;
   logic [NUM_PINS-1:0]     pol = '0;
   logic [CS_W-1:0]         cs_idx = '0;
   logic [NUM_CS*SEL_W-1:0] pin_sel = '0;
   logic [NUM_CS-1:0]       rd_en = '0;
   logic [NUM_CS-1:0]       wr_en = '0;
   logic [NUM_CS-1:0]       rd_sync = '0;
   logic [NUM_CS-1:0]       wr_sync = '0;
   logic                    wr = 1'b0;
   logic                    edge_stb = 1'b0;
   logic                    win = 1'b0;
   logic                    stall;
   logic                    ready;

   int vectors = 0;
   int fails   = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   wait_pin_monitor #(
      .NUM_CS   (NUM_CS),
      .NUM_PINS (NUM_PINS),
      .SEL_W    (SEL_W)
   ) i_wait_pin_monitor (
      .clk              (clk),
      .rst_n            (rst_n),
      .wait_pin_i       (wait_pin),
      .pin_active_low_i (pol),
      .cs_idx_i         (cs_idx),
      .cs_pin_sel_i     (pin_sel),
      .cs_rd_mon_en_i   (rd_en),
      .cs_wr_mon_en_i   (wr_en),
      .cs_rd_sync_i     (rd_sync),
      .cs_wr_sync_i     (wr_sync),
      .acc_write_i      (wr),
      .ext_clk_edge_i   (edge_stb),
      .mon_window_i     (win),
      .stall_o          (stall),
      .ready_o          (ready)
   );

   task automatic chk(input string tag, input logic act, input logic exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0b expected=%0b (cs=%0d sel=%h pol=%b wr=%0b pins=%b win=%0b)",
                  tag, act, exp, cs_idx, pin_sel, pol, wr, wait_pin, win);
      end
   endtask

   task automatic wait_neg(input int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   task automatic strobe();
      edge_stb = 1'b1;
      @(negedge clk);
      edge_stb = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      // R10: held in reset with a synchronous read on an active-low pin held low
      cs_idx  = 2'd0;
      pin_sel = '0;
      rd_en   = 4'b0001;
      rd_sync = 4'b0001;
      pol     = 2'b01;
      wait_pin = 2'b00;
      win     = 1'b1;
      wait_neg(4);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R10", stall, 1'b0);
      chk("R10", ready, 1'b1);
      wait_neg(3);
      chk("R10", stall, 1'b0);
      strobe();
      chk("R7", stall, 1'b1);

      // R6: asynchronous read, active-high pin 0
      rd_sync  = 4'b0000;
      pol      = 2'b00;
      wait_pin = 2'b00;
      wait_neg(3);
      chk("R6", stall, 1'b0);
      wait_pin = 2'b01;
      @(negedge clk);
      chk("R6", stall, 1'b0);
      @(negedge clk);
      chk("R6", stall, 1'b1);
      wait_pin = 2'b00;
      @(negedge clk);
      chk("R6", stall, 1'b1);
      @(negedge clk);
      chk("R6", stall, 1'b0);

      // R7: synchronous read holds its capture between strobes
      rd_sync = 4'b0001;
      strobe();
      chk("R7", stall, 1'b0);
      wait_pin = 2'b01;
      wait_neg(4);
      chk("R7", stall, 1'b0);
      strobe();
      chk("R7", stall, 1'b1);
      wait_pin = 2'b00;
      wait_neg(4);
      chk("R7", stall, 1'b1);
      strobe();
      chk("R7", stall, 1'b0);

      // Full sweep: other chip-selects get contrasting settings
      for (int cs = 0; cs < NUM_CS; cs++)
      for (int sel = 0; sel < 4; sel++)
      for (int pl = 0; pl < 4; pl++)
      for (int w = 0; w < 2; w++)
      for (int en = 0; en < 2; en++)
      for (int sy = 0; sy < 2; sy++)
      for (int wn = 0; wn < 2; wn++)
      for (int lv = 0; lv < 4; lv++) begin
         logic [1:0] pl_v;
         logic [1:0] lv_v;
         int         p;
         logic       busy;
         logic       exp;
         pl_v = 2'(pl);
         lv_v = 2'(lv);
         cs_idx = 2'(cs);
         for (int c = 0; c < NUM_CS; c++) begin
            if (c == cs) begin
               pin_sel[c*SEL_W +: SEL_W] = 2'(sel);
               rd_en[c]   = (w == 0) ? 1'(en) : 1'(1 - en);
               wr_en[c]   = (w == 1) ? 1'(en) : 1'(1 - en);
               rd_sync[c] = 1'(sy);
               wr_sync[c] = 1'(sy);
            end else begin
               pin_sel[c*SEL_W +: SEL_W] = (sel == 1) ? 2'd0 : 2'd1;
               rd_en[c]   = 1'(1 - en);
               wr_en[c]   = 1'(1 - en);
               rd_sync[c] = 1'(1 - sy);
               wr_sync[c] = 1'(1 - sy);
            end
         end
         pol      = pl_v;
         wr       = 1'(w);
         win      = 1'(wn);
         wait_pin = lv_v;
         wait_neg(2);
         strobe();
         p    = (sel == 1) ? 1 : 0;
         busy = lv_v[p] ^ pl_v[p];
         exp  = 1'(wn) & 1'(en) & busy;
         if (wn == 0)       chk("R8", stall, exp);
         else if (en == 0)  chk((w == 1) ? "R5" : "R4", stall, exp);
         else if (sel >= 2) chk("R2", stall, exp);
         else               chk("R1 R3", stall, exp);
         chk("R9", ready, ~exp);
      end

      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule